// File: doc/BRIEF.md
# Interrupt Source Masking and Routing

This block collects 32 level-sensitive interrupt lines and decides where each one goes. Every source has a pending bit driven by hardware and a second one that software can raise. An enable mask gates the normal path. A per-source select mask steers each line either to a single fast-interrupt request or to a masked normal status vector. A downstream priority unit consumes that vector.

Software reaches the block through a word-addressed register port. It reads the status, pending and configuration words, plus eight constant identification bytes. The enable mask and the software pending bits have no plain write. Each has one word that only sets bits and another that only clears them, so concurrent owners never need a read-modify-write. The routing mask and the one-bit protection flag are written whole. Any access the map does not define returns zero, changes nothing, and raises a one-cycle error strobe.

Top module: `irq_route_top`

## Requirements
- R1: Each hardware pending bit copies its `src_i` line one clock after the line is sampled. Word 2 reads the OR of hardware and software pending bits.
- R2: `norm_status_o`, also readable at word 0, equals (hardware OR software pending) AND enable AND NOT route-select.
- R3: The fast status (word 1) equals (hardware OR software pending) AND route-select, with no enable gating. `fast_irq_o` is high when any bit of it is set.
- R4: A write to word 4 ORs the data into the enable mask. A write to word 5 clears every enable bit where the data is 1. Word 4 reads the mask.
- R5: A write to word 6 ORs the data into the software pending bits. A write to word 7 clears the bits where the data is 1. Word 6 reads them.
- R6: A write to word 3 replaces the route-select mask (1 = fast path). Word 3 reads it back.
- R7: Word 8 holds only data bit 0 as the protection flag. It reads back zero-extended.
- R8: A write to word 0 is accepted without error and changes no state.
- R9: Byte offsets 0xFE0, 0xFE4, ... 0xFFC read the identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in that order.
- R10: Every other access returns zero and has no effect. This covers write-only words read, read-only words other than 0 written, undefined words, and addresses whose two low bits are not zero. For such an access `bus_err_o` is high for exactly the cycle after it.
- R11: After reset the enable mask, software bits, route-select mask, protection flag, hardware pending bits, read data and error strobe are all zero.
- R12: `bus_rdata_o` is loaded at the clock edge of a read access and holds its value through writes and idle cycles.

Word index N is byte offset 4*N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive interrupt lines |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_err_o | output | 1 | One-cycle strobe after an unmapped access |
| norm_status_o | output | 32 | Masked normal-interrupt status vector |
| fast_irq_o | output | 1 | Fast-interrupt request |

## Verification
The assertions check, on every cycle, several properties. Each hardware pending bit tracks its input one clock later. The set-only and clear-only words change the enable and software bits exactly as ordered. No source appears on the normal vector while it is disabled or routed fast. The fast request never rises without a routed pending source. A write to word 0 leaves all state alone, and the error strobe only follows an access. Only the bench scenarios can show the read-back values of the whole map, the identification bytes, the zero and no-effect result of misaligned and undefined accesses, and that read data holds across writes. They also show that a fast source is reported with its enable bit clear.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // word indices (byte offset = 4 * index)
  localparam int W_NSTAT  = 0;
  localparam int W_FSTAT  = 1;
  localparam int W_PEND   = 2;
  localparam int W_ROUTE  = 3;
  localparam int W_EN_SET = 4;
  localparam int W_EN_CLR = 5;
  localparam int W_SW_SET = 6;
  localparam int W_SW_CLR = 7;
  localparam int W_LOCK   = 8;

  localparam int ID_COUNT = 8;
  localparam int ID_IDX_W = $clog2(ID_COUNT);

  typedef struct packed {
    logic rd_nstat;
    logic rd_fstat;
    logic rd_pend;
    logic rd_route;
    logic rd_en;
    logic rd_sw;
    logic rd_lock;
    logic rd_id;
    logic wr_route;
    logic wr_en_set;
    logic wr_en_clr;
    logic wr_sw_set;
    logic wr_sw_clr;
    logic wr_lock;
    logic hit;
  } acc_dec_t;

  function automatic logic [7:0] id_byte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h90;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output acc_dec_t            dec_o,
  output logic [ID_IDX_W-1:0] id_idx_o
);

  localparam int WW = ADDR_W - 2;
  // identification words occupy the top of the window
  localparam logic [WW-1:0] ID_BASE = WW'((2 ** WW) - ID_COUNT);

  logic [WW-1:0] word;
  logic          aligned;

  assign word     = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign id_idx_o = word[ID_IDX_W-1:0];

  always_comb begin
    dec_o = '0;
    if (aligned) begin
      if (we_i) begin
        dec_o.wr_route  = (word == WW'(W_ROUTE));
        dec_o.wr_en_set = (word == WW'(W_EN_SET));
        dec_o.wr_en_clr = (word == WW'(W_EN_CLR));
        dec_o.wr_sw_set = (word == WW'(W_SW_SET));
        dec_o.wr_sw_clr = (word == WW'(W_SW_CLR));
        dec_o.wr_lock   = (word == WW'(W_LOCK));
        // word 0 is read-only: accepted, no effect
        dec_o.hit = (word == WW'(W_NSTAT)) | dec_o.wr_route | dec_o.wr_en_set |
                    dec_o.wr_en_clr | dec_o.wr_sw_set | dec_o.wr_sw_clr |
                    dec_o.wr_lock;
      end else begin
        dec_o.rd_nstat = (word == WW'(W_NSTAT));
        dec_o.rd_fstat = (word == WW'(W_FSTAT));
        dec_o.rd_pend  = (word == WW'(W_PEND));
        dec_o.rd_route = (word == WW'(W_ROUTE));
        dec_o.rd_en    = (word == WW'(W_EN_SET));
        dec_o.rd_sw    = (word == WW'(W_SW_SET));
        dec_o.rd_lock  = (word == WW'(W_LOCK));
        dec_o.rd_id    = (word >= ID_BASE);
        dec_o.hit = dec_o.rd_nstat | dec_o.rd_fstat | dec_o.rd_pend |
                    dec_o.rd_route | dec_o.rd_en | dec_o.rd_sw |
                    dec_o.rd_lock | dec_o.rd_id;
      end
    end
  end

endmodule

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] raw_o
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_o[i] <= 1'b0;
      else         raw_o[i] <= src_i[i];
    end
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  acc_dec_t           dec_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] sw_o,
  output logic [NUM_SRC-1:0] route_o,
  output logic               lock_o
);

  logic [NUM_SRC-1:0] wd;
  assign wd = wdata_i[NUM_SRC-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      sw_o    <= '0;
      route_o <= '0;
      lock_o  <= 1'b0;
    end else if (acc_i) begin
      if (dec_i.wr_en_set) en_o    <= en_o | wd;
      if (dec_i.wr_en_clr) en_o    <= en_o & ~wd;
      if (dec_i.wr_sw_set) sw_o    <= sw_o | wd;
      if (dec_i.wr_sw_clr) sw_o    <= sw_o & ~wd;
      if (dec_i.wr_route)  route_o <= wd;
      if (dec_i.wr_lock)   lock_o  <= wdata_i[0];
    end
  end

endmodule

// File: rtl/irq_status_calc.sv
module irq_status_calc #(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] raw_i,
  input  logic [NUM_SRC-1:0] sw_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] route_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] nstat_o,
  output logic [NUM_SRC-1:0] fstat_o,
  output logic               fast_o
);

  assign pend_o  = raw_i | sw_i;
  assign nstat_o = pend_o & en_i & ~route_i;
  assign fstat_o = pend_o & route_i;
  assign fast_o  = |fstat_o;

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_sel_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               bus_err_o,
  output logic [NUM_SRC-1:0] norm_status_o,
  output logic               fast_irq_o
);

  acc_dec_t            dec;
  logic [ID_IDX_W-1:0] id_idx;
  logic [NUM_SRC-1:0]  raw_w, en_w, sw_w, route_w, pend_w, fstat_w;
  logic                lock_w;
  logic [DATA_W-1:0]   rd_d;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .dec_o    (dec),
    .id_idx_o (id_idx)
  );

  irq_src_capture #(.NUM_SRC(NUM_SRC)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .raw_o  (raw_w)
  );

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (bus_sel_i),
    .dec_i   (dec),
    .wdata_i (bus_wdata_i),
    .en_o    (en_w),
    .sw_o    (sw_w),
    .route_o (route_w),
    .lock_o  (lock_w)
  );

  irq_status_calc #(.NUM_SRC(NUM_SRC)) u_calc (
    .raw_i   (raw_w),
    .sw_i    (sw_w),
    .en_i    (en_w),
    .route_i (route_w),
    .pend_o  (pend_w),
    .nstat_o (norm_status_o),
    .fstat_o (fstat_w),
    .fast_o  (fast_irq_o)
  );

  always_comb begin
    rd_d = '0;
    if (dec.rd_nstat) rd_d = DATA_W'(norm_status_o);
    if (dec.rd_fstat) rd_d = DATA_W'(fstat_w);
    if (dec.rd_pend)  rd_d = DATA_W'(pend_w);
    if (dec.rd_route) rd_d = DATA_W'(route_w);
    if (dec.rd_en)    rd_d = DATA_W'(en_w);
    if (dec.rd_sw)    rd_d = DATA_W'(sw_w);
    if (dec.rd_lock)  rd_d = DATA_W'(lock_w);
    if (dec.rd_id)    rd_d = DATA_W'(id_byte(id_idx));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_rdata_o <= '0;
      bus_err_o   <= 1'b0;
    end else begin
      bus_err_o <= bus_sel_i & ~dec.hit;
      if (bus_sel_i && !bus_we_i) bus_rdata_o <= rd_d;
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_sel_i,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic               bus_err_o,
  input logic [NUM_SRC-1:0] norm_status_o,
  input logic               fast_irq_o,
  input logic [NUM_SRC-1:0] raw_w,
  input logic [NUM_SRC-1:0] en_w,
  input logic [NUM_SRC-1:0] sw_w,
  input logic [NUM_SRC-1:0] route_w
);

  localparam int WW = ADDR_W - 2;

  logic          wr_ok;
  logic [WW-1:0] word;
  logic [NUM_SRC-1:0] wd;

  assign wr_ok = bus_sel_i && bus_we_i && (bus_addr_i[1:0] == 2'b00);
  assign word  = bus_addr_i[ADDR_W-1:2];
  assign wd    = bus_wdata_i[NUM_SRC-1:0];

  // R1
  raw_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> raw_w == $past(src_i));

  // R2
  norm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((norm_status_o & route_w) == '0) && ((norm_status_o & ~en_w) == '0));

  // R3
  fast_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_irq_o |-> (route_w != '0) && ((raw_w | sw_w) != '0));

  // R4
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == WW'(4)) |=> en_w == ($past(en_w) | $past(wd)));

  // R4
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == WW'(5)) |=> en_w == ($past(en_w) & ~$past(wd)));

  // R5
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == WW'(6)) |=> sw_w == ($past(sw_w) | $past(wd)));

  // R5
  sw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == WW'(7)) |=> sw_w == ($past(sw_w) & ~$past(wd)));

  // R8
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && word == WW'(0)) |=>
      $stable(en_w) && $stable(sw_w) && $stable(route_w) && !bus_err_o);

  // R10
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |=> !bus_err_o);

endmodule

bind irq_route_top irq_route_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_i         (src_i),
  .bus_sel_i     (bus_sel_i),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_err_o     (bus_err_o),
  .norm_status_o (norm_status_o),
  .fast_irq_o    (fast_irq_o),
  .raw_w         (raw_w),
  .en_w          (en_w),
  .sw_w          (sw_w),
  .route_w       (route_w)
);

// File: tb/irq_route_top_tb_top.sv
`timescale 1ns/1ps
module irq_route_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [31:0] nstat;
  logic        fast;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_route_top dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .src_i         (src),
    .bus_sel_i     (sel),
    .bus_we_i      (we),
    .bus_addr_i    (addr),
    .bus_wdata_i   (wdata),
    .bus_rdata_o   (rdata),
    .bus_err_o     (err),
    .norm_status_o (nstat),
    .fast_irq_o    (fast)
  );

  // ---------------- reference model ----------------
  logic [7:0]  ids [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
  logic [31:0] m_raw, m_sw, m_en, m_rt, m_rd;
  logic        m_lock, m_err;
  logic [31:0] m_r;
  bit          m_hit;
  int          m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_sw = 0; m_en = 0; m_rt = 0; m_rd = 0; m_lock = 0; m_err = 0;
    end else begin
      m_hit = 0; m_r = 0; m_w = int'(addr) / 4;
      if (sel) begin
        if (addr[1:0] == 2'b00) begin
          if (!we) begin
            case (m_w)
              0: begin m_hit = 1; m_r = (m_raw | m_sw) & m_en & ~m_rt; end
              1: begin m_hit = 1; m_r = (m_raw | m_sw) & m_rt; end
              2: begin m_hit = 1; m_r = m_raw | m_sw; end
              3: begin m_hit = 1; m_r = m_rt; end
              4: begin m_hit = 1; m_r = m_en; end
              6: begin m_hit = 1; m_r = m_sw; end
              8: begin m_hit = 1; m_r = {31'b0, m_lock}; end
              default: if (m_w >= 1016) begin m_hit = 1; m_r = {24'b0, ids[m_w-1016]}; end
            endcase
          end else begin
            case (m_w)
              0: m_hit = 1;
              3: begin m_hit = 1; m_rt = wdata; end
              4: begin m_hit = 1; m_en = m_en | wdata; end
              5: begin m_hit = 1; m_en = m_en & ~wdata; end
              6: begin m_hit = 1; m_sw = m_sw | wdata; end
              7: begin m_hit = 1; m_sw = m_sw & ~wdata; end
              8: begin m_hit = 1; m_lock = wdata[0]; end
              default: ;
            endcase
          end
        end
        m_err = !m_hit;
        if (!we) m_rd = m_r;
      end else begin
        m_err = 0;
      end
      m_raw = src;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata === m_rd, "R12 rdata vs model", rdata, m_rd);
      chk(err === m_err, "R10 err vs model", {31'b0, err}, {31'b0, m_err});
      chk(nstat === ((m_raw | m_sw) & m_en & ~m_rt), "R2 norm vs model", nstat,
          (m_raw | m_sw) & m_en & ~m_rt);
      chk(fast === (|((m_raw | m_sw) & m_rt)), "R3 fast vs model", {31'b0, fast},
          {31'b0, |((m_raw | m_sw) & m_rt)});
    end
  end

  // ---------------- stimulus ----------------
  task automatic acc(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    acc(1'b0, a, '0);
    chk(rdata === exp, tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    @(negedge clk);
    chk(nstat === 0 && fast === 0 && err === 0, "R11 outputs after reset", nstat, 0);
    rd_chk(12'h000, 32'h0, "R11 word0");
    rd_chk(12'h004, 32'h0, "R11 word1");
    rd_chk(12'h008, 32'h0, "R11 word2");
    rd_chk(12'h00C, 32'h0, "R11 word3");
    rd_chk(12'h010, 32'h0, "R11 word4");
    rd_chk(12'h018, 32'h0, "R11 word6");
    rd_chk(12'h020, 32'h0, "R11 word8");

    // R1 hardware capture
    src = 32'h0000_00F0;
    @(negedge clk);
    rd_chk(12'h008, 32'h0000_00F0, "R1 raw read");
    rd_chk(12'h000, 32'h0, "R2 none enabled");

    // R4 set/clear enable
    wr(12'h010, 32'h30);
    wr(12'h010, 32'h01);
    rd_chk(12'h010, 32'h31, "R4 enable set accumulates");
    chk(nstat === 32'h30, "R2 norm after enable", nstat, 32'h30);
    wr(12'h014, 32'h10);
    rd_chk(12'h010, 32'h21, "R4 enable clear");
    chk(nstat === 32'h20, "R2 norm after clear", nstat, 32'h20);

    // R5 software bits
    wr(12'h018, 32'h0001_0001);
    rd_chk(12'h018, 32'h0001_0001, "R5 soft set");
    rd_chk(12'h008, 32'h0001_00F1, "R1 raw or soft");
    chk(nstat === 32'h21, "R2 norm with soft", nstat, 32'h21);
    wr(12'h01C, 32'h1);
    rd_chk(12'h018, 32'h0001_0000, "R5 soft clear");

    // R6 / R3 routing
    wr(12'h00C, 32'h0001_0020);
    rd_chk(12'h00C, 32'h0001_0020, "R6 route write");
    rd_chk(12'h004, 32'h0001_0020, "R3 fast status ignores enable");
    chk(fast === 1'b1, "R3 fast request high", {31'b0, fast}, 32'h1);
    chk(nstat === 32'h0, "R2 routed source removed", nstat, 32'h0);
    wr(12'h00C, 32'h4);
    rd_chk(12'h00C, 32'h4, "R6 route replaced");
    chk(fast === 1'b0, "R3 fast request low", {31'b0, fast}, 32'h0);
    chk(nstat === 32'h20, "R2 norm after reroute", nstat, 32'h20);

    // R7 protection
    wr(12'h020, 32'hFFFF_FFFE);
    rd_chk(12'h020, 32'h0, "R7 bit0 only (0)");
    wr(12'h020, 32'h3);
    rd_chk(12'h020, 32'h1, "R7 bit0 only (1)");

    // R8 read-only word 0
    wr(12'h000, 32'hFFFF_FFFF);
    chk(err === 1'b0, "R8 no error on word0 write", {31'b0, err}, 32'h0);
    rd_chk(12'h010, 32'h21, "R8 enable untouched");
    rd_chk(12'h018, 32'h0001_0000, "R8 soft untouched");
    rd_chk(12'h00C, 32'h4, "R8 route untouched");

    // R9 identification
    for (int i = 0; i < 8; i++)
      rd_chk(12'hFE0 + 12'(4 * i), {24'b0, ids[i]}, "R9 id byte");

    // R10 unmapped accesses
    acc(1'b0, 12'h014, '0);
    chk(rdata === 0 && err === 1'b1, "R10 write-only word read", {rdata[30:0], err}, 32'h1);
    @(negedge clk);
    chk(err === 1'b0, "R10 strobe one cycle", {31'b0, err}, 32'h0);
    acc(1'b0, 12'h012, '0);
    chk(rdata === 0 && err === 1'b1, "R10 misaligned read", {rdata[30:0], err}, 32'h1);
    wr(12'h040, 32'hFFFF_FFFF);
    chk(err === 1'b1, "R10 undefined write strobe", {31'b0, err}, 32'h1);
    wr(12'h011, 32'hFFFF_FFFF);
    chk(err === 1'b1, "R10 misaligned write strobe", {31'b0, err}, 32'h1);
    rd_chk(12'h010, 32'h21, "R10 enable unchanged");
    wr(12'h008, 32'hFFFF_FFFF);
    chk(err === 1'b1, "R10 read-only word2 write", {31'b0, err}, 32'h1);
    rd_chk(12'h018, 32'h0001_0000, "R10 soft unchanged");

    // R12 read data holds across writes
    rd_chk(12'h010, 32'h21, "R12 load");
    wr(12'h018, 32'h2);
    chk(rdata === 32'h21, "R12 hold across write", rdata, 32'h21);
    wr(12'h01C, 32'h2);

    // R1 source drop
    src = 32'h0;
    @(negedge clk);
    rd_chk(12'h008, 32'h0001_0000, "R1 source released");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule